// File: doc/BRIEF.md
# Periodic Refresh Scheduler with Postponement

This block paces AUTO REFRESH commands for a DDR SDRAM. A free-running interval counter produces a refresh-due event once every refresh period, which adds one unit to a pending-refresh count. While the memory controller is busy, the pending refreshes are deferred. Once the controller goes idle, or the count reaches its ceiling of eight, the block asks the command arbiter for a slot with all banks closed. When it receives that slot, it issues refreshes back to back until the debt is cleared. After every refresh it holds off activates and further refreshes for the refresh cycle time.

The block also owns the clock enable. A self-refresh request is served with a refresh command issued while the clock enable is driven low. That command clears the outstanding debt. Dropping the request raises the clock enable again and starts two exit windows: a short one that blocks non-read commands and a long one that blocks reads.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, `cke` is 1 and `pend_cnt`, `ref_req`, `cmd_ref`, `urgent`, `block_act` and `block_rd` are all 0.
- R2: Outside self-refresh and with no refresh issued, `pend_cnt` (a binary count) rises by exactly one every `REFI_CYC` clocks.
- R3: `urgent` is 1 exactly when `pend_cnt` equals `MAX_PEND`. While `busy` is 1 and `sr_req` is 0, `ref_req` is 1 only when `urgent` is 1.
- R4: `pend_cnt` never exceeds `MAX_PEND`. A refresh-due event at the ceiling leaves it at `MAX_PEND`.
- R5: `cmd_ref` is 1 only in a cycle where `ref_req`, `grant` and `banks_idle` are all 1. An auto refresh lowers `pend_cnt` by one.
- R6: After a refresh command, `block_act` is 1 for the next `RFC_CYC-1` cycles and no other refresh command is issued in that time.
- R7: While `busy` is 0 and `grant` and `banks_idle` are 1, pending refreshes are issued exactly `RFC_CYC` cycles apart until `pend_cnt` is 0.
- R8: With `sr_req` at 1 and a slot granted, `cmd_ref` is 1 in the same cycle that `cke` goes to 0. `cke` then stays 0 and `pend_cnt` stays 0 until `sr_req` falls.
- R9: `cke` returns to 1 one cycle after `sr_req` falls. From that cycle on, `block_act` is 1 for `XSNR_CYC` cycles and `block_rd` is 1 for `XSRD_CYC` cycles.
- R10: While in self-refresh, no refresh command is issued, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Controller has traffic queued |
| banks_idle | input | 1 | All banks are precharged |
| grant | input | 1 | Arbiter grants the command slot to this block |
| sr_req | input | 1 | Request to enter (1) or leave (0) self-refresh |
| ref_req | output | 1 | Asks the arbiter to close all banks and grant a slot |
| cmd_ref | output | 1 | Refresh command this cycle (self-refresh entry when `cke` is 0) |
| cke | output | 1 | Clock enable to the memory |
| urgent | output | 1 | Debt is at its ceiling, so refresh preempts traffic |
| block_act | output | 1 | Activate and refresh are not allowed |
| block_rd | output | 1 | Read is not allowed |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of postponed refreshes |

## Verification
The assertions take for granted that reset is applied from time zero. They also assume that `banks_idle` and `grant` come from an arbiter that changes them only between clock edges and not in response to `cmd_ref` within the same cycle. The stimulus keeps to this by changing every input one nanosecond after a rising edge and sampling at the falling edge. The scoreboard predicts each refresh command: whether `cke` is 0 with it, and its spacing from the previous command. It flags any command it did not predict, so refreshes that appear in self-refresh or while the debt is zero are caught.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int REFI_CYC = 1950,
  parameter int RFC_CYC  = 19,
  parameter int XSNR_CYC = 20,
  parameter int XSRD_CYC = 200,
  parameter int MAX_PEND = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          banks_idle,
  input  logic          grant,
  input  logic          sr_req,
  output logic          ref_req,
  output logic          cmd_ref,
  output logic          cke,
  output logic          urgent,
  output logic          block_act,
  output logic          block_rd,
  output logic [PW-1:0] pend_cnt
);
  localparam int TW = $clog2(REFI_CYC);
  localparam int RW = $clog2(RFC_CYC);
  localparam int XW = $clog2(XSRD_CYC + 1);

  logic [TW-1:0] tcnt;
  logic [RW-1:0] rfc_cnt;
  logic [XW-1:0] xs_cnt;
  logic          in_sr, tick, ready, issue, enter_sr, want;

  assign tick      = tcnt == TW'(REFI_CYC - 1);
  assign urgent    = pend_cnt == PW'(MAX_PEND);
  assign block_act = (rfc_cnt != '0) || (xs_cnt > XW'(XSRD_CYC - XSNR_CYC));
  assign block_rd  = xs_cnt != '0;
  assign want      = (pend_cnt != '0) && (!busy || urgent);
  assign ref_req   = !in_sr && (sr_req || want);
  assign ready     = grant && banks_idle && !block_act;
  assign enter_sr  = !in_sr && sr_req && ready;
  assign issue     = !in_sr && !sr_req && want && ready;
  assign cmd_ref   = issue || enter_sr;
  assign cke       = !in_sr && !enter_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt     <= '0;
      pend_cnt <= '0;
      rfc_cnt  <= '0;
      xs_cnt   <= '0;
      in_sr    <= 1'b0;
    end else begin
      if (in_sr || enter_sr) tcnt <= '0;
      else if (tick)         tcnt <= '0;
      else                   tcnt <= tcnt + 1'b1;

      if (in_sr || enter_sr)              pend_cnt <= '0;
      else if (tick && !issue && !urgent) pend_cnt <= pend_cnt + 1'b1;
      else if (!tick && issue)            pend_cnt <= pend_cnt - 1'b1;

      if (issue)                rfc_cnt <= RW'(RFC_CYC - 1);
      else if (rfc_cnt != '0)   rfc_cnt <= rfc_cnt - 1'b1;

      if (enter_sr)             in_sr <= 1'b1;
      else if (in_sr && !sr_req) in_sr <= 1'b0;

      if (in_sr && !sr_req)     xs_cnt <= XW'(XSRD_CYC);
      else if (xs_cnt != '0)    xs_cnt <= xs_cnt - 1'b1;
    end
  end
endmodule

module refresh_sched_chk #(
  parameter int RFC_CYC  = 19,
  parameter int MAX_PEND = 8,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          banks_idle,
  input logic          grant,
  input logic          sr_req,
  input logic          ref_req,
  input logic          cmd_ref,
  input logic          cke,
  input logic          urgent,
  input logic          block_act,
  input logic          block_rd,
  input logic [PW-1:0] pend_cnt
);
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= 16'hFFFF;
    else if (cmd_ref)        since <= '0;
    else if (since != 16'hFFFF) since <= since + 1'b1;
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(MAX_PEND));

  assert_cmd_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ref |-> (grant && banks_idle && ref_req));

  assert_busy_defers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sr_req && ref_req) |-> urgent);

  assert_rfc_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ref |-> (since >= 16'(RFC_CYC - 1)));

  assert_pend_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt > $past(pend_cnt)) |-> (pend_cnt == PW'($past(pend_cnt) + 1'b1)));

  assert_sr_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> cmd_ref);

  assert_exit_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (block_act && block_rd));

  assert_quiet_in_sr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$fell(cke)) |-> !cmd_ref);
endmodule

bind refresh_sched refresh_sched_chk #(
  .RFC_CYC(RFC_CYC), .MAX_PEND(MAX_PEND), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .banks_idle(banks_idle),
  .grant(grant), .sr_req(sr_req), .ref_req(ref_req), .cmd_ref(cmd_ref),
  .cke(cke), .urgent(urgent), .block_act(block_act), .block_rd(block_rd),
  .pend_cnt(pend_cnt)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int REFI = 200, RFC = 5, XSNR = 6, XSRD = 20, MAXP = 8;
  localparam int PW = $clog2(MAXP + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, busy, banks_idle, grant, sr_req;
  logic ref_req, cmd_ref, cke, urgent, block_act, block_rd;
  logic [PW-1:0] pend_cnt;

  refresh_sched #(.REFI_CYC(REFI), .RFC_CYC(RFC), .XSNR_CYC(XSNR),
                  .XSRD_CYC(XSRD), .MAX_PEND(MAXP)) i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .busy(busy), .banks_idle(banks_idle),
    .grant(grant), .sr_req(sr_req), .ref_req(ref_req), .cmd_ref(cmd_ref),
    .cke(cke), .urgent(urgent), .block_act(block_act), .block_rd(block_rd),
    .pend_cnt(pend_cnt));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0, nchk = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
  endtask

  typedef struct { logic cke; int gap; } exp_t;
  exp_t q[$];
  int last_ref = -1000;
  exp_t e;

  always @(negedge clk) begin
    if (rst_n && cmd_ref) begin
      if (q.size() == 0) check(0, "R5 unpredicted refresh command", 1, 0);
      else begin
        e = q.pop_front();
        check(cke == e.cke, "R8 cke with refresh command", int'(cke), int'(e.cke));
        if (e.gap != 0) check(cyc - last_ref == e.gap, "R7 refresh spacing", cyc - last_ref, e.gap);
      end
      last_ref = cyc;
    end
  end

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask

  task automatic wait_pend(input int v);
    do @(negedge clk); while (int'(pend_cnt) != v);
  endtask

  initial begin
    #(4 * 200000);
    errs++; nchk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t1, t2, na, nr;
    rst_n = 1'b0; busy = 1'b0; banks_idle = 1'b1; grant = 1'b0; sr_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cke == 1'b1, "R1 cke in reset", int'(cke), 1);
    check(pend_cnt == 0 && urgent == 0, "R1 count in reset", int'(pend_cnt), 0);
    check(ref_req == 0 && cmd_ref == 0, "R1 request in reset", int'(ref_req), 0);
    check(block_act == 0 && block_rd == 0, "R1 blocks in reset", int'(block_act), 0);

    drive_edge(); rst_n = 1'b1; busy = 1'b1;
    wait_pend(1); t1 = cyc;
    wait_pend(2); t2 = cyc;
    check(t2 - t1 == REFI, "R2 refresh interval", t2 - t1, REFI);
    wait_pend(7);
    check(ref_req == 0, "R3 deferred while busy", int'(ref_req), 0);
    check(urgent == 0, "R3 not urgent below ceiling", int'(urgent), 0);
    wait_pend(8);
    check(urgent == 1, "R3 urgent at ceiling", int'(urgent), 1);
    check(ref_req == 1, "R3 urgent request while busy", int'(ref_req), 1);
    while (cyc < t1 + REFI * 8 + 2) @(negedge clk);
    check(int'(pend_cnt) == MAXP, "R4 saturation", int'(pend_cnt), MAXP);
    check(cmd_ref == 0, "R5 no command without grant", int'(cmd_ref), 0);

    drive_edge(); q.push_back('{1'b1, 0}); grant = 1'b1;
    repeat (10) @(negedge clk);
    check(int'(pend_cnt) == MAXP - 1, "R5 refresh lowers debt", int'(pend_cnt), MAXP - 1);
    check(ref_req == 0 && urgent == 0, "R3 busy defers again", int'(ref_req), 0);

    drive_edge();
    q.push_back('{1'b1, 0});
    for (int i = 0; i < 6; i++) q.push_back('{1'b1, RFC});
    busy = 1'b0;
    repeat (40) @(negedge clk);
    check(pend_cnt == 0 && ref_req == 0, "R7 debt drained", int'(pend_cnt), 0);
    check(q.size() == 0, "R7 all drain refreshes seen", q.size(), 0);

    drive_edge(); banks_idle = 1'b0;
    wait_pend(1);
    repeat (10) @(negedge clk);
    check(cmd_ref == 0 && int'(pend_cnt) == 1, "R5 open banks hold refresh", int'(pend_cnt), 1);
    check(ref_req == 1, "R5 request stays up", int'(ref_req), 1);
    drive_edge(); q.push_back('{1'b1, 0}); banks_idle = 1'b1;
    @(negedge clk);
    check(cmd_ref == 1, "R5 issue once banks idle", int'(cmd_ref), 1);
    for (int i = 1; i < RFC; i++) begin
      @(negedge clk);
      check(block_act == 1 && cmd_ref == 0, "R6 refresh cycle hold", int'(block_act), 1);
    end
    @(negedge clk);
    check(block_act == 0, "R6 hold ends", int'(block_act), 0);

    drive_edge(); q.push_back('{1'b0, 0}); sr_req = 1'b1;
    @(negedge clk);
    check(cmd_ref == 1 && cke == 0, "R8 entry command with cke low", int'(cke), 0);
    repeat (300) @(negedge clk);
    check(cke == 0 && pend_cnt == 0, "R8 held in self-refresh", int'(pend_cnt), 0);
    check(cmd_ref == 0 && ref_req == 0, "R10 quiet in self-refresh", int'(cmd_ref), 0);

    drive_edge(); sr_req = 1'b0;
    @(negedge clk);
    check(cke == 0, "R9 exit cycle cke", int'(cke), 0);
    @(negedge clk);
    check(cke == 1, "R9 cke raised", int'(cke), 1);
    na = 0; nr = 0;
    for (int i = 0; i < 30; i++) begin
      if (block_act) na++;
      if (block_rd) nr++;
      @(negedge clk);
    end
    check(na == XSNR, "R9 non-read exit window", na, XSNR);
    check(nr == XSRD, "R9 read exit window", nr, XSRD);
    check(q.size() == 0, "R8 all predicted commands seen", q.size(), 0);

    summary();
    $finish;
  end
endmodule